// File: doc/BRIEF.md
# LCD Blink Timing Controller

This block derives the blink timing of a segment LCD driver from the display clock. A prescaler counts display clock cycles and flips a blink phase every half period. The half period is chosen by a 2-bit blink mode: mode 1 gives a blink period of 768 clocks, mode 2 gives 1536 clocks and mode 3 gives 3072 clocks. With a 1536 Hz display clock these periods are 2 Hz, 1 Hz and 0.5 Hz. Mode 0 stops blinking.

The block drives two outputs. The first is a blank strobe that blanks the whole display. The second is a bank select that shows either the primary RAM bank or its alternate. In the static and 1:2 multiplex drive modes, an alternate-bank enable makes the blink phase swap the displayed bank instead of blanking the display. This lets chosen segments blink without any further command traffic. In the 1:3 and 1:4 drive modes no alternate bank exists, so the bank select stays on the primary bank and the whole display blinks. Clearing the display enable blanks every segment.

The inputs are register fields that have already been decoded. They are sampled on the display clock.

Top module: `lcd_blink_ctrl`

## Requirements
- R1: During and after a synchronous active-low reset, the prescaler is cleared and the phase is visible. While `disp_en` is 1, `blank` is 0 and `bank_sel` is 0 (primary bank).
- R2: `blink_mode` 0 means no blinking. The output `blank` equals the inverse of `disp_en`, and `bank_sel` stays 0.
- R3: In `blink_mode` 1 the phase lasts 384 clocks visible and then 384 clocks blinked, so one period is 768 clocks.
- R4: In `blink_mode` 2 each half of the period lasts 768 clocks, so one period is 1536 clocks.
- R5: In `blink_mode` 3 each half of the period lasts 1536 clocks, so one period is 3072 clocks.
- R6: Each blink period starts with the visible half and ends with the blinked half. A blinked half drives `blank`=1 when alternate-bank blinking is not active.
- R7: When `blink_mode` changes, the clock edge that first samples the new value restarts the prescaler. The next full half period after that edge is the visible phase.
- R8: Alternate-bank blinking is active when `alt_bank_en`=1 and `mux_mode` is 0 (static) or 1 (1:2). While it is active, `blank` is never raised by the blink phase, and `bank_sel` is 0 in the first half and 1 in the second half.
- R9: With `mux_mode` 2 (1:3) or 3 (1:4), `bank_sel` stays 0 whatever `alt_bank_en` is, and the whole display blinks through `blank`.
- R10: When `disp_en` is 0, `blank` is 1 in every blink mode and every phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blink_mode | input | 2 | 0 off, 1 period 768, 2 period 1536, 3 period 3072 clocks |
| alt_bank_en | input | 1 | Blink by swapping RAM banks instead of blanking |
| mux_mode | input | 2 | 0 static, 1 1:2, 2 1:3, 3 1:4 multiplex drive |
| disp_en | input | 1 | Display enable; 0 blanks all segments |
| blank | output | 1 | 1 blanks every segment |
| bank_sel | output | 1 | 0 primary RAM bank, 1 alternate bank |

## Verification
Every blink mode is swept against every drive mode, with alternate-bank blinking both off and on. This shows whether the phase ends up on `blank` or on `bank_sel`, and it exposes a drive mode that wrongly allows the bank swap. Directed runs measure the visible and blinked half periods in cycles for each mode. They tell apart an off-by-one in a divider and an exchanged mode decode. A mode change made in the middle of a period, a reset pulse and display disable cases check the restart rule and the blanking priority. Constrained random changes to all inputs, held for random lengths, are compared cycle by cycle with a bench model of the requirements.

// File: rtl/lcd_blink_pkg.sv
// Package: shared encodings for the LCD blink timing controller.
// Assumes the blink and drive mode fields arrive already decoded, 2 bits each.
package lcd_blink_pkg;

    typedef enum logic [1:0] {
        BLINK_OFF  = 2'd0,
        BLINK_FAST = 2'd1,
        BLINK_MID  = 2'd2,
        BLINK_SLOW = 2'd3
    } blink_mode_e;

    typedef enum logic [1:0] {
        DRV_STATIC = 2'd0,
        DRV_MUX2   = 2'd1,
        DRV_MUX3   = 2'd2,
        DRV_MUX4   = 2'd3
    } drive_mode_e;

    // Drive modes that own an alternate RAM bank.
    function automatic logic has_alt_bank(input logic [1:0] drv);
        return (drv == DRV_STATIC) || (drv == DRV_MUX2);
    endfunction

endpackage

// File: rtl/blink_rate_decode.sv
// Module: blink_rate_decode
// Turns the blink mode into a half-period length in display clocks.
// The fastest mode uses BASE_HALF, and each slower mode doubles it.
// Assumes mode 0 (off) is handled by the prescaler; it returns BASE_HALF for it.
module blink_rate_decode #(
    parameter int BASE_HALF = 384,
    parameter int CNT_W     = $clog2(BASE_HALF * 4)
) (
    input  logic [1:0]       blink_mode,
    output logic [CNT_W-1:0] half_len
);

    localparam logic [CNT_W-1:0] HALF1 = CNT_W'(BASE_HALF);
    localparam logic [CNT_W-1:0] HALF2 = CNT_W'(BASE_HALF * 2);
    localparam logic [CNT_W-1:0] HALF3 = CNT_W'(BASE_HALF * 4);

    // Purpose: choose the half-period length for the selected blink rate.
    always_comb begin
        unique case (blink_mode)
            2'd2:    half_len = HALF2;
            2'd3:    half_len = HALF3;
            default: half_len = HALF1;
        endcase
    end

endmodule

// File: rtl/blink_prescaler.sv
// Module: blink_prescaler
// Counts display clocks and flips the blink phase once per half period.
// It restarts in the visible phase (phase 0) after a reset, after any change
// of blink mode, and for as long as blinking is off.
// Assumes half_len is at least 2 and is stable while the mode is unchanged.
module blink_prescaler #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       blink_mode,
    input  logic [CNT_W-1:0] half_len,
    output logic             phase
);

    logic [CNT_W-1:0] cnt;
    logic [1:0]       mode_q;
    logic             restart;
    logic             wrap;

    // Purpose: spot a mode change or the off mode, both of which hold the prescaler.
    always_comb begin
        restart = (blink_mode != mode_q) || (blink_mode == 2'd0);
        wrap    = (cnt == half_len - CNT_W'(1));
    end

    // Purpose: count within the half period and toggle the phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            phase  <= 1'b0;
            mode_q <= blink_mode;
        end else begin
            mode_q <= blink_mode;
            if (restart) begin
                cnt   <= '0;
                phase <= 1'b0;
            end else if (wrap) begin
                cnt   <= '0;
                phase <= ~phase;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    AST_CNT_IN_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < half_len || blink_mode != mode_q) // R3
        else $error("count beyond half period");

    AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_mode != mode_q) |=> (cnt == '0 && !phase)) // R7
        else $error("mode change did not restart prescaler");

    AST_OFF_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_mode == 2'd0) |=> !phase) // R2
        else $error("phase moved while blinking off");

endmodule

// File: rtl/blink_output_gate.sv
// Module: blink_output_gate
// Maps the blink phase to the whole-display blank or to the bank select.
// The bank swap is used only when an alternate bank exists in the drive mode.
// Clearing the display enable overrides everything else and blanks the display.
// Assumes phase is 0 while blinking is off.
module blink_output_gate
    import lcd_blink_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phase,
    input  logic       alt_bank_en,
    input  logic [1:0] mux_mode,
    input  logic       disp_en,
    output logic       blank,
    output logic       bank_sel
);

    logic swap_ok;

    // Purpose: route the phase either to the bank select or to the blank strobe.
    always_comb begin
        swap_ok  = alt_bank_en && has_alt_bank(mux_mode);
        bank_sel = swap_ok && phase;
        blank    = !disp_en || (phase && !swap_ok);
    end

    AST_NO_SWAP_HIGH_MUX: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_mode[1]) |-> !bank_sel) // R9
        else $error("bank swap in a mode without alternate bank");

    AST_DISABLE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_en) |-> blank) // R10
        else $error("display not blanked while disabled");

    AST_SWAP_NO_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel && disp_en) |-> !blank) // R8
        else $error("blanked during bank swap");

endmodule

// File: rtl/lcd_blink_ctrl.sv
// Module: lcd_blink_ctrl (top)
// Blink timing for a segment LCD driver: a rate decode, a prescaler and an output gate.
// Assumes all inputs are synchronous to clk, the display clock.
module lcd_blink_ctrl #(
    parameter int BASE_HALF = 384
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] blink_mode,
    input  logic       alt_bank_en,
    input  logic [1:0] mux_mode,
    input  logic       disp_en,
    output logic       blank,
    output logic       bank_sel
);

    localparam int CNT_W = $clog2(BASE_HALF * 4);

    logic [CNT_W-1:0] half_len;
    logic             phase;

    blink_rate_decode #(
        .BASE_HALF (BASE_HALF),
        .CNT_W     (CNT_W)
    ) u_decode (
        .blink_mode (blink_mode),
        .half_len   (half_len)
    );

    blink_prescaler #(
        .CNT_W (CNT_W)
    ) u_prescaler (
        .clk        (clk),
        .rst_n      (rst_n),
        .blink_mode (blink_mode),
        .half_len   (half_len),
        .phase      (phase)
    );

    blink_output_gate u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase       (phase),
        .alt_bank_en (alt_bank_en),
        .mux_mode    (mux_mode),
        .disp_en     (disp_en),
        .blank       (blank),
        .bank_sel    (bank_sel)
    );

    AST_RESET_VISIBLE: assert property (@(posedge clk)
        (!rst_n) |=> (!bank_sel && (blank == !disp_en))) // R1
        else $error("reset did not give visible primary bank");

endmodule

// File: tb/lcd_blink_ctrl_tb.sv
module lcd_blink_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int BASE_HALF  = 384;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] blink_mode = 2'd0;
    logic       alt_bank_en = 1'b0;
    logic [1:0] mux_mode = 2'd0;
    logic       disp_en = 1'b1;
    logic       blank;
    logic       bank_sel;

    int n_tests = 0;
    int n_fail  = 0;

    // reference model state
    int m_cnt = 0;
    logic m_ph = 1'b0;
    logic [1:0] m_prev = 2'd0;
    logic cmp_en = 1'b0;
    int seg_err = 0;
    logic act_b, act_s, exp_b, exp_s;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_blink_ctrl #(.BASE_HALF(BASE_HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .blink_mode(blink_mode),
        .alt_bank_en(alt_bank_en), .mux_mode(mux_mode), .disp_en(disp_en),
        .blank(blank), .bank_sel(bank_sel)
    );

    function automatic int half_of(input logic [1:0] m);
        return BASE_HALF << (m - 1);
    endfunction

    function automatic logic swap_active(input logic a, input logic [1:0] mx);
        return a && (mx < 2);
    endfunction

    function automatic logic exp_blank(input logic ph);
        return !disp_en || (ph && !swap_active(alt_bank_en, mux_mode));
    endfunction

    function automatic logic exp_bank(input logic ph);
        return ph && swap_active(alt_bank_en, mux_mode);
    endfunction

    // model of R1..R7 at the clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ph = 1'b0; m_prev = blink_mode;
        end else if (blink_mode != m_prev || blink_mode == 2'd0) begin
            m_cnt = 0; m_ph = 1'b0; m_prev = blink_mode;
        end else if (m_cnt == half_of(blink_mode) - 1) begin
            m_cnt = 0; m_ph = ~m_ph;
        end else begin
            m_cnt = m_cnt + 1;
        end
    end

    // cycle compare away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            exp_b = exp_blank(m_ph);
            exp_s = exp_bank(m_ph);
            if (blank !== exp_b || bank_sel !== exp_s) begin
                if (seg_err == 0) begin
                    act_b = blank; act_s = bank_sel;
                end
                seg_err++;
            end
        end
    end

    task automatic check(input string req, input logic ok, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic seg_begin();
        seg_err = 0;
    endtask

    task automatic seg_end(input string req);
        check(req, seg_err == 0, {act_b, act_s}, {exp_b, exp_s});
    endtask

    // count negedge samples while sig equals val
    task automatic measure(input bit use_bank, input logic val, output int n);
        n = 0;
        while (((use_bank ? bank_sel : blank) === val) && n < 10000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int meas;
        #(CLK_PERIOD * 250000);
        n_fail++; n_tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int meas;
        void'($urandom(32'h1A2B));
        cycles(3);
        // R1: reset state
        check("R1 blank", blank === 1'b0, blank, 0);
        check("R1 bank", bank_sel === 1'b0, bank_sel, 0);
        rst_n = 1'b1;
        cmp_en = 1'b1;

        // R2: blinking off stays visible, disable blanks (R10)
        seg_begin(); alt_bank_en = 1'b1; cycles(2000); seg_end("R2");
        check("R2 visible", blank === 1'b0 && bank_sel === 1'b0, blank, 0);
        disp_en = 1'b0; cycles(2);
        check("R10 off-mode", blank === 1'b1, blank, 1);
        disp_en = 1'b1; alt_bank_en = 1'b0;

        // R3/R4/R5/R6: measured half periods, whole-display blink
        for (int m = 1; m <= 3; m++) begin
            blink_mode = 2'(m); mux_mode = 2'd0;
            @(posedge clk); @(negedge clk);
            measure(1'b0, 1'b0, meas);
            check(m == 1 ? "R3 visible half" : m == 2 ? "R4 visible half" : "R5 visible half",
                  meas == half_of(2'(m)), meas, half_of(2'(m)));
            measure(1'b0, 1'b1, meas);
            check("R6 blanked half", meas == half_of(2'(m)), meas, half_of(2'(m)));
        end

        // R8: bank swap measured in static mode
        blink_mode = 2'd0; cycles(2);
        alt_bank_en = 1'b1; blink_mode = 2'd2;
        @(posedge clk); @(negedge clk);
        measure(1'b1, 1'b0, meas);
        check("R8 primary half", meas == 768, meas, 768);
        check("R8 no blank", blank === 1'b0, blank, 0);
        measure(1'b1, 1'b1, meas);
        check("R8 alternate half", meas == 768, meas, 768);

        // every blink mode x drive mode x alt enable, cycle compared
        for (int m = 1; m <= 3; m++)
            for (int mx = 0; mx < 4; mx++)
                for (int a = 0; a < 2; a++) begin
                    seg_begin();
                    blink_mode = 2'd0; cycles(1);
                    blink_mode = 2'(m); mux_mode = 2'(mx); alt_bank_en = a[0];
                    cycles(2 * half_of(2'(m)) + 5);
                    seg_end(mx >= 2 ? "R9 sweep" : (a != 0 ? "R8 sweep" : "R6 sweep"));
                end

        // R7: mode change mid period restarts in visible phase
        blink_mode = 2'd1; alt_bank_en = 1'b0; mux_mode = 2'd3;
        cycles(500);
        check("R7 pre blanked", blank === 1'b1, blank, 1);
        blink_mode = 2'd3;
        @(posedge clk); @(negedge clk);
        measure(1'b0, 1'b0, meas);
        check("R7 restart visible", meas == 1536, meas, 1536);

        // R10: disable during blank and during swap
        seg_begin();
        disp_en = 1'b0; cycles(3000);
        check("R10 disabled", blank === 1'b1, blank, 1);
        mux_mode = 2'd1; alt_bank_en = 1'b1; cycles(3000);
        disp_en = 1'b1; cycles(100);
        seg_end("R10 sweep");

        // R1: reset pulse mid run
        blink_mode = 2'd1; mux_mode = 2'd0; alt_bank_en = 1'b0; cycles(400);
        rst_n = 1'b0; cycles(1); rst_n = 1'b1;
        check("R1 after pulse", blank === 1'b0 && bank_sel === 1'b0, blank, 0);

        // constrained random, checked against the model
        seg_begin();
        for (int i = 0; i < 40; i++) begin
            blink_mode  = 2'($urandom_range(0, 3));
            mux_mode    = 2'($urandom_range(0, 3));
            alt_bank_en = 1'($urandom_range(0, 1));
            disp_en     = ($urandom_range(0, 7) != 0);
            cycles($urandom_range(1, 1200));
        end
        seg_end("R9 random");

        cmp_en = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule